// File: doc/BRIEF.md
# Multi-View Register File

This block is the general register storage of a small 16-bit processor core. It holds six 16-bit registers: four data registers (data0 to data3) and two address registers (addr0, addr1). A single copy of the storage is reached through three views. A word view covers any of the six registers. A byte view covers only the low or high byte of data0 and data1. A 32-bit view covers one of three fixed register pairs.

Two combinational read ports and one write port are provided. Each port carries a 4-bit selector and a 2-bit size code. Writes take effect on the rising clock edge. Reads are taken directly from storage, so a read in the cycle of a write returns the value held before that edge. A selector and size combination that names no view raises a per-port illegal flag. Such an access returns zero and, on the write port, changes nothing.

Top module: `multi_view_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears all six registers to zero at the clock edge where it is sampled high.
- R2: A word write (size code 1) with selector index `sel[2:0]` 0..5 stores `wr_data[15:0]` into data0..data3, addr0 or addr1 respectively at the next rising edge. `sel[3]` is ignored.
- R3: A byte write (size code 0) to index 0 or 1 stores `wr_data[7:0]` into the low byte when `sel[3]`=0, or into the high byte when `sel[3]`=1. The other byte of that register keeps its value.
- R4: A byte read of index 0 or 1 returns the byte chosen by `sel[3]` (0 low, 1 high) in data bits [7:0], with bits [31:8] zero.
- R5: Size code 2 selects a 32-bit pair. Index 0 is {data2, data0}, index 1 is {data3, data1} and index 4 is {addr1, addr0}, with the first-named register in bits [31:16]. A pair write updates both members on the same edge, and a pair read returns them in that order.
- R6: A word read returns the selected register in bits [15:0], with bits [31:16] zero.
- R7: A byte access to index 2..5 raises the port's illegal flag. A read returns zero, and a write changes no register.
- R8: Index 6 or 7 with any size, a pair access to index 2, 3 or 5, and size code 3 are all illegal. They raise the flag, read as zero and write nothing.
- R9: A read of a register written in the same cycle returns the value held before that write's clock edge.
- R10: The two read ports decode and return data independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear |
| rd_a_sel | input | 4 | Read port A selector: [3] byte half, [2:0] register index |
| rd_a_size | input | 2 | Read port A size code: 0 byte, 1 word, 2 pair, 3 reserved |
| rd_a_data | output | 32 | Read port A data, zero-extended |
| rd_a_illegal | output | 1 | Read port A selector/size names no view |
| rd_b_sel | input | 4 | Read port B selector |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_data | output | 32 | Read port B data |
| rd_b_illegal | output | 1 | Read port B selector/size names no view |
| wr_en | input | 1 | Write request for this cycle |
| wr_sel | input | 4 | Write selector |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data; byte uses [7:0], word uses [15:0], pair uses all |
| wr_illegal | output | 1 | High when `wr_en` is set with an illegal selector/size |

## Verification
The bench goes after the seams between views. A byte write must leave the opposite byte intact; a design that wrote the whole word would clear or corrupt it. Pair accesses must place the non-adjacent upper member in bits [31:16]; a swapped or adjacent-index mapping shows up as wrong halves or as writes landing on the wrong registers. Byte or pair access to a register that lacks that view must be rejected; a design that decoded loosely would alias onto data2/data3 or the address registers. The bench also reads a register in the same cycle it is written, where a design with a bypass would return the new value early.

// File: rtl/mvrf_pkg.sv
package mvrf_pkg;
  localparam int NREG  = 6;
  localparam int IDX_W = 3;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef struct packed {
    logic             legal;
    size_e            kind;
    logic             high;
    logic [IDX_W-1:0] lo;
    logic [IDX_W-1:0] hi;
  } view_t;

  // pair index -> upper member; the lower member is the index itself
  function automatic logic [IDX_W-1:0] pair_upper(input logic [IDX_W-1:0] lo);
    case (lo)
      3'd0:    return 3'd2;
      3'd1:    return 3'd3;
      3'd4:    return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic pair_ok(input logic [IDX_W-1:0] lo);
    return (lo == 3'd0) || (lo == 3'd1) || (lo == 3'd4);
  endfunction

  function automatic view_t view_decode(input logic [SEL_W-1:0] sel,
                                        input logic [1:0]       size);
    view_t v;
    v      = '0;
    v.kind = size_e'(size);
    v.high = sel[SEL_W-1];
    case (v.kind)
      SZ_BYTE: v.legal = (sel[IDX_W-1:1] == '0);
      SZ_WORD: v.legal = (sel[IDX_W-1:0] < IDX_W'(NREG));
      SZ_LONG: v.legal = pair_ok(sel[IDX_W-1:0]);
      default: v.legal = 1'b0;
    endcase
    if (v.legal) begin
      v.lo = sel[IDX_W-1:0];
      if (v.kind == SZ_LONG) v.hi = pair_upper(sel[IDX_W-1:0]);
    end
    return v;
  endfunction
endpackage

// File: rtl/rf_read_view.sv
module rf_read_view
  import mvrf_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [SEL_W-1:0]                sel,
  input  logic [1:0]                      size,
  input  logic [NREG-1:0][WORD_W-1:0]     regs,
  output logic [2*WORD_W-1:0]             data,
  output logic                            illegal
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int LONG_W = 2 * WORD_W;

  view_t v;
  logic  rd_byte_evt;

  assign v           = view_decode(sel, size);
  assign illegal     = !v.legal;
  assign rd_byte_evt = v.legal && (v.kind == SZ_BYTE);

  always_comb begin
    data = '0;
    if (v.legal) begin
      case (v.kind)
        SZ_BYTE: data[BYTE_W-1:0] = v.high ? regs[v.lo][WORD_W-1:BYTE_W]
                                           : regs[v.lo][BYTE_W-1:0];
        SZ_WORD: data[WORD_W-1:0] = regs[v.lo];
        SZ_LONG: data             = {regs[v.hi], regs[v.lo]};
        default: data             = '0;
      endcase
    end
  end

  AST_RD_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
    rd_byte_evt |-> (data[LONG_W-1:BYTE_W] == '0)); // R4
  AST_RD_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (data == '0)); // R8
endmodule

// File: rtl/rf_store.sv
module rf_store
  import mvrf_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic [1:0]                  wr_size,
  input  logic [2*WORD_W-1:0]         wr_data,
  output logic [NREG-1:0][WORD_W-1:0] regs,
  output logic                        wr_illegal
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int LONG_W = 2 * WORD_W;

  view_t v;
  logic  wr_fire, wr_byte, wr_long, wr_reject;

  assign v          = view_decode(wr_sel, wr_size);
  assign wr_fire    = wr_en && v.legal;
  assign wr_byte    = wr_fire && (v.kind == SZ_BYTE);
  assign wr_long    = wr_fire && (v.kind == SZ_LONG);
  assign wr_reject  = wr_en && !v.legal;
  assign wr_illegal = wr_reject;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else if (wr_fire) begin
      case (v.kind)
        SZ_BYTE: begin
          if (v.high) regs[v.lo][WORD_W-1:BYTE_W] <= wr_data[BYTE_W-1:0];
          else        regs[v.lo][BYTE_W-1:0]      <= wr_data[BYTE_W-1:0];
        end
        SZ_WORD: regs[v.lo] <= wr_data[WORD_W-1:0];
        SZ_LONG: begin
          regs[v.lo] <= wr_data[WORD_W-1:0];
          regs[v.hi] <= wr_data[LONG_W-1:WORD_W];
        end
        default: ;
      endcase
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (regs == '0)); // R1
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_reject |=> $stable(regs)); // R7

  for (genvar gi = 0; gi < 2; gi++) begin : g_byte_chk
    AST_BYTE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
      (wr_byte && !v.high && v.lo == IDX_W'(gi)) |=> $stable(regs[gi][WORD_W-1:BYTE_W])); // R3
    AST_BYTE_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
      (wr_byte && v.high && v.lo == IDX_W'(gi)) |=> $stable(regs[gi][BYTE_W-1:0])); // R3
  end

  for (genvar gr = 0; gr < NREG; gr++) begin : g_pair_chk
    AST_PAIR_LOWER: assert property (@(posedge clk) disable iff (rst)
      (wr_long && v.lo == IDX_W'(gr)) |=> (regs[gr] == $past(wr_data[WORD_W-1:0]))); // R5
    AST_PAIR_UPPER: assert property (@(posedge clk) disable iff (rst)
      (wr_long && v.hi == IDX_W'(gr)) |=> (regs[gr] == $past(wr_data[LONG_W-1:WORD_W]))); // R5
  end
endmodule

// File: rtl/multi_view_regfile.sv
module multi_view_regfile
  import mvrf_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          rd_a_sel,
  input  logic [1:0]          rd_a_size,
  output logic [2*WORD_W-1:0] rd_a_data,
  output logic                rd_a_illegal,
  input  logic [3:0]          rd_b_sel,
  input  logic [1:0]          rd_b_size,
  output logic [2*WORD_W-1:0] rd_b_data,
  output logic                rd_b_illegal,
  input  logic                wr_en,
  input  logic [3:0]          wr_sel,
  input  logic [1:0]          wr_size,
  input  logic [2*WORD_W-1:0] wr_data,
  output logic                wr_illegal
);
  localparam int NRD    = 2;
  localparam int LONG_W = 2 * WORD_W;

  logic [NREG-1:0][WORD_W-1:0] regs;
  logic [NRD-1:0][SEL_W-1:0]   rsel;
  logic [NRD-1:0][1:0]         rsize;
  logic [NRD-1:0][LONG_W-1:0]  rdata;
  logic [NRD-1:0]              rill;

  assign rsel[0]  = rd_a_sel;
  assign rsel[1]  = rd_b_sel;
  assign rsize[0] = rd_a_size;
  assign rsize[1] = rd_b_size;

  rf_store #(.WORD_W(WORD_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_size    (wr_size),
    .wr_data    (wr_data),
    .regs       (regs),
    .wr_illegal (wr_illegal)
  );

  for (genvar gp = 0; gp < NRD; gp++) begin : g_rd
    rf_read_view #(.WORD_W(WORD_W)) u_view (
      .clk     (clk),
      .rst     (rst),
      .sel     (rsel[gp]),
      .size    (rsize[gp]),
      .regs    (regs),
      .data    (rdata[gp]),
      .illegal (rill[gp])
    );
  end

  assign rd_a_data    = rdata[0];
  assign rd_b_data    = rdata[1];
  assign rd_a_illegal = rill[0];
  assign rd_b_illegal = rill[1];
endmodule

// File: tb/multi_view_regfile_bench.sv
module multi_view_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
  logic [1:0]  rd_a_size = 2'd1, rd_b_size = 2'd1, wr_size = 2'd1;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        rd_a_illegal, rd_b_illegal, wr_illegal;
  logic        wr_en = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] m [6];

  always #5 clk = ~clk;

  multi_view_regfile u_multi_view_regfile (
    .clk(clk), .rst(rst),
    .rd_a_sel(rd_a_sel), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data), .rd_a_illegal(rd_a_illegal),
    .rd_b_sel(rd_b_sel), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data), .rd_b_illegal(rd_b_illegal),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data), .wr_illegal(wr_illegal)
  );

  // reference view: {illegal, data}
  function automatic logic [32:0] ref_read(input logic [3:0] s, input logic [1:0] z);
    int r;
    r = int'(s[2:0]);
    if (z == 2'd0) begin
      if (r > 1) return {1'b1, 32'h0};
      return {1'b0, 24'h0, (s[3] ? m[r][15:8] : m[r][7:0])};
    end
    if (z == 2'd1) begin
      if (r > 5) return {1'b1, 32'h0};
      return {1'b0, 16'h0, m[r]};
    end
    if (z == 2'd2) begin
      if (r == 0) return {1'b0, m[2], m[0]};
      if (r == 1) return {1'b0, m[3], m[1]};
      if (r == 4) return {1'b0, m[5], m[4]};
    end
    return {1'b1, 32'h0};
  endfunction

  function automatic string rtag(input logic [3:0] s, input logic [1:0] z);
    logic [32:0] q;
    q = ref_read(s, z);
    if (z == 2'd3 || s[2:0] > 3'd5) return "R8";
    if (z == 2'd0) return q[32] ? "R7" : "R4";
    if (z == 2'd1) return "R6";
    return q[32] ? "R8" : "R5";
  endfunction

  task automatic ref_write(input logic [3:0] s, input logic [1:0] z, input logic [31:0] d);
    int r;
    r = int'(s[2:0]);
    if (ref_read(s, z) & 33'h1_0000_0000 ) return;
    case (z)
      2'd0: if (s[3]) m[r][15:8] = d[7:0]; else m[r][7:0] = d[7:0];
      2'd1: m[r] = d[15:0];
      2'd2: begin
        m[r] = d[15:0];
        if (r == 0) m[2] = d[31:16];
        else if (r == 1) m[3] = d[31:16];
        else m[5] = d[31:16];
      end
      default: ;
    endcase
  endtask

  task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs against the
  // pre-edge model, then commit the write to the model after the edge
  task automatic step(input logic we, input logic [3:0] ws, input logic [1:0] wz,
                      input logic [31:0] wd, input logic [3:0] as, input logic [1:0] az,
                      input logic [3:0] bs, input logic [1:0] bz, input string atag);
    logic [32:0] ea, eb;
    string ta;
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_size = wz; wr_data = wd;
    rd_a_sel = as; rd_a_size = az; rd_b_sel = bs; rd_b_size = bz;
    #1;
    ea = ref_read(as, az);
    eb = ref_read(bs, bz);
    ta = (atag == "") ? rtag(as, az) : atag;
    check({rd_a_illegal, rd_a_data} === ea, ta, {rd_a_illegal, rd_a_data}, ea);
    check({rd_b_illegal, rd_b_data} === eb, {"R10/", rtag(bs, bz)}, {rd_b_illegal, rd_b_data}, eb);
    check(wr_illegal === (we && ref_read(ws, wz)[32]), (we ? rtag(ws, wz) : "R2"),
          {32'h0, wr_illegal}, {32'h0, we && ref_read(ws, wz)[32]});
    @(posedge clk);
    if (we) ref_write(ws, wz, wd);
  endtask

  task automatic check_all_zero();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      wr_en = 1'b0; rd_a_sel = 4'(i); rd_a_size = 2'd1;
      #1;
      check(rd_a_data === 32'h0, "R1", {1'b0, rd_a_data}, 33'h0);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0de));
    for (int i = 0; i < 6; i++) m[i] = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check_all_zero();                                                     // R1

    // R2: word writes to all six registers, read back next cycle
    for (int i = 0; i < 6; i++)
      step(1'b1, 4'(i) | 4'h8, 2'd1, 32'hFFFF_0000 | (32'h1111 * (i + 1)), 4'h0, 2'd1, 4'h5, 2'd1, "");
    for (int i = 0; i < 6; i++)
      step(1'b0, 4'h0, 2'd1, 32'h0, 4'(i), 2'd1, 4'(5 - i), 2'd1, "R2");

    // R3: byte writes leave the other byte alone
    step(1'b1, 4'h0, 2'd0, 32'hFFFF_FFAB, 4'h0, 2'd1, 4'h1, 2'd1, "");
    step(1'b1, 4'h9, 2'd0, 32'h0000_00CD, 4'h0, 2'd1, 4'h8, 2'd0, "R3");
    step(1'b0, 4'h0, 2'd0, 32'h0, 4'h1, 2'd1, 4'h9, 2'd0, "R3");
    check(m[0] == 16'h11AB && m[1] == 16'hCD22, "R3", {17'h0, m[0]}, 33'h11AB);

    // R5: pair writes and reads in each fixed order
    step(1'b1, 4'h1, 2'd2, 32'hDEAD_BEEF, 4'h3, 2'd1, 4'h1, 2'd1, "");
    step(1'b1, 4'h4, 2'd2, 32'hA1A1_A0A0, 4'h3, 2'd1, 4'h1, 2'd2, "R5");
    step(1'b1, 4'h0, 2'd2, 32'h2222_0000, 4'h4, 2'd1, 4'h5, 2'd1, "R5");
    step(1'b0, 4'h0, 2'd0, 32'h0, 4'h4, 2'd2, 4'h0, 2'd2, "R5");

    // R7 / R8: rejected writes leave storage untouched
    step(1'b1, 4'h2, 2'd0, 32'h0000_0077, 4'h2, 2'd0, 4'h2, 2'd1, "R7");
    step(1'b1, 4'hC, 2'd0, 32'h0000_0066, 4'h5, 2'd1, 4'h4, 2'd1, "R7");
    step(1'b1, 4'h2, 2'd2, 32'h5555_5555, 4'h2, 2'd2, 4'h2, 2'd1, "R8");
    step(1'b1, 4'h6, 2'd1, 32'h0000_4444, 4'h6, 2'd1, 4'h0, 2'd3, "R8");
    step(1'b1, 4'h0, 2'd3, 32'h0000_3333, 4'h0, 2'd1, 4'h2, 2'd1, "R8");
    step(1'b0, 4'h0, 2'd0, 32'h0, 4'h0, 2'd1, 4'h6, 2'd1, "R8");

    // R9: same-cycle read of the written register sees the old value
    step(1'b1, 4'h4, 2'd1, 32'h0000_9999, 4'h4, 2'd1, 4'h4, 2'd2, "R9");
    step(1'b1, 4'h0, 2'd2, 32'h7777_8888, 4'h0, 2'd2, 4'h0, 2'd0, "R9");
    step(1'b0, 4'h0, 2'd0, 32'h0, 4'h4, 2'd1, 4'h0, 2'd2, "R9");

    // random mix
    for (int k = 0; k < 800; k++)
      step(1'($urandom), 4'($urandom), 2'($urandom), $urandom,
           4'($urandom), 2'($urandom), 4'($urandom), 2'($urandom), "");

    // R1: reset mid-run clears everything
    @(negedge clk); rst = 1'b1; wr_en = 1'b0;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 6; i++) m[i] = 16'h0;
    check_all_zero();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule